// File: doc/BRIEF.md
# Channel Address Deinterleaver

This block turns a system address into the address seen by one memory channel. The memory controller and the channel are already known when a request arrives. The block holds a table of target ranges. Each range has a base word, a wayness word and one offset word per channel. A request carries an address and a channel index. The block finds the first range that contains the address and subtracts that channel's offset. It then removes the socket interleave and the channel interleave. Removing an interleave means dividing the address, shifted down by the interleave granularity, by the way count. The way count can be three.

Software or boot logic loads the range table through a simple configuration write port before traffic starts. A request is accepted on a single-cycle `reqValid` while the block is not busy. The result is presented with a one-cycle `done` pulse. It consists of a channel address, the socket way count, the channel way count and an error flag for an address that falls in no range.

Top module: `chanDeinterleaver`

## Requirements
- R1: Entry i covers base = base word bits 31..12 shifted left by 26, up to limit = (wayness word bits 31..12 shifted left by 26) OR (2^26 - 1), both ends inclusive. When several entries cover the address, the lowest index wins.
- R2: If no entry covers the address, the result has error = 1, chanAddr = 0, sktWays = 0 and chanWays = 0.
- R3: sktWays = 1 << (wayness bits 11..10), so it is 1, 2, 4 or 8. chanWays = (wayness bits 9..8) + 1, so it is 1 to 4. Both come from the matched entry.
- R4: The socket granularity code is base bits 5..4 and the channel granularity code is base bits 7..6. Codes 0, 1, 2 and 3 select interleave bit positions 6, 8, 12 and 30.
- R5: The offset used is the offset word of the requested channel for the matched entry: bits 23..4, shifted left by 26. It is subtracted from the address modulo 2^ADDR_W before any interleave step.
- R6: One interleave step with bit position g, way count w and low-bits source L produces (((v >> g) / w) << g) | (L & (2^g - 1)). The division is exact integer division, including w = 3.
- R7: When chanWays = 3 and the socket bit position is greater than the channel bit position, the channel step runs first, then the socket step. Each step takes its low bits from its own input value.
- R8: In every other case the socket step runs first, then the channel step. Both steps take their low bits from the original, un-offset address.
- R9: Counting from the clock edge that accepts the request, done is high after 1 edge for a miss and after 3 edges for a hit whose chanWays is not 3. A hit with chanWays = 3 needs ADDR_W + 4 edges, which is 50 at the defaults.
- R10: busy is high from the accepting edge until done. A reqValid seen while busy is ignored and does not alter the result in flight.
- R11: A configuration write takes effect on the edge on which cfgWe is high. cfgSel 0 writes the base word of cfgEntry, 1 writes its wayness word, 2 writes its offset word for channel cfgChan, and 3 writes nothing. Requests accepted later use the new contents.
- R12: After reset all outputs are zero. done is a one-cycle pulse, and chanAddr, sktWays, chanWays and error hold their values until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Table write strobe |
| cfgSel | input | 2 | Word select: 0 base, 1 wayness, 2 channel offset |
| cfgEntry | input | ENT_W (3) | Entry index written |
| cfgChan | input | CH_W (2) | Channel for an offset write |
| cfgData | input | 32 | Word written |
| reqValid | input | 1 | Request strobe, taken when busy is low |
| reqAddr | input | ADDR_W (46) | System address |
| reqChan | input | CH_W (2) | Channel index within the controller |
| busy | output | 1 | A request is in flight |
| done | output | 1 | One-cycle result pulse |
| error | output | 1 | No entry covered the address |
| chanAddr | output | ADDR_W (46) | Channel-local address |
| sktWays | output | 4 | Socket way count of the matched entry |
| chanWays | output | 3 | Channel way count of the matched entry |

## Verification
The result is not due a fixed number of cycles after the request. It is due 1, 3 or 50 edges after the accepting edge, depending on whether the address misses, hits a range without three-way channel interleave, or hits a three-way range. The bench first computes from its own copy of the table which case applies. It then counts edges from acceptance until done is seen. All outputs are sampled on the falling edge, and the bench requires the edge count to equal the predicted latency before it compares the address, way counts and error flag. One falling edge after each result, it checks again that done has dropped and the outputs have held.

// File: rtl/cad_pkg.sv
package cad_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;     // capture request
    logic match;    // capture table lookup and subtract offset
    logic stepWr;   // write step result into working value
    logic useDiv;   // step result comes from the divider
    logic divInit;  // seed the divider
    logic divIter;  // one divider iteration
    logic stepSel;  // 0 first step, 1 second step
    logic finOk;    // publish a hit result
    logic finErr;   // publish a miss result
  } cadStrobe_t;

  // Granularity code to interleave bit position
  function automatic logic [4:0] granBit(input logic [1:0] code);
    logic [4:0] pos;
    unique case (code)
      2'd0: pos = 5'd6;
      2'd1: pos = 5'd8;
      2'd2: pos = 5'd12;
      default: pos = 5'd30;
    endcase
    return pos;
  endfunction

endpackage

// File: rtl/cadTables.sv
module cadTables #(
  parameter int ADDR_W = 46,
  parameter int NUM_ENT = 8,
  parameter int NUM_CH = 3,
  parameter int REGION_LSB = 26,
  localparam int ENT_W = $clog2(NUM_ENT),
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ENT_W-1:0]  cfgEntry,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [31:0]       cfgData,
  input  logic [ADDR_W-1:0] lookAddr,
  input  logic [CH_W-1:0]   lookChan,
  output logic              hit,
  output logic [1:0]        hitSktCode,
  output logic [1:0]        hitChnCode,
  output logic [1:0]        hitSktK,
  output logic [1:0]        hitChnM1,
  output logic [19:0]       hitOffField
);

  localparam logic [63:0] REGION_MASK = (64'd1 << REGION_LSB) - 64'd1;

  // Only the fields the decode uses are stored
  logic [19:0] loField  [NUM_ENT];
  logic [1:0]  sktCode  [NUM_ENT];
  logic [1:0]  chnCode  [NUM_ENT];
  logic [19:0] hiField  [NUM_ENT];
  logic [1:0]  sktK     [NUM_ENT];
  logic [1:0]  chnM1    [NUM_ENT];
  logic [19:0] offField [NUM_ENT][NUM_CH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int e = 0; e < NUM_ENT; e++) begin
        loField[e] <= '0;
        sktCode[e] <= '0;
        chnCode[e] <= '0;
        hiField[e] <= '0;
        sktK[e]    <= '0;
        chnM1[e]   <= '0;
        for (int c = 0; c < NUM_CH; c++) offField[e][c] <= '0;
      end
    end else if (cfgWe) begin
      unique case (cfgSel)
        2'd0: begin
          loField[cfgEntry] <= cfgData[31:12];
          chnCode[cfgEntry] <= cfgData[7:6];
          sktCode[cfgEntry] <= cfgData[5:4];
        end
        2'd1: begin
          hiField[cfgEntry] <= cfgData[31:12];
          sktK[cfgEntry]    <= cfgData[11:10];
          chnM1[cfgEntry]   <= cfgData[9:8];
        end
        2'd2: begin
          for (int c = 0; c < NUM_CH; c++)
            if (cfgChan == CH_W'(c)) offField[cfgEntry][c] <= cfgData[23:4];
        end
        default: ;
      endcase
    end
  end

  logic [NUM_ENT-1:0] hitVec;

  generate
    for (genvar g = 0; g < NUM_ENT; g++) begin : gEnt
      logic [ADDR_W-1:0] entLo;
      logic [ADDR_W-1:0] entHi;
      assign entLo = ADDR_W'(64'(loField[g]) << REGION_LSB);
      assign entHi = ADDR_W'((64'(hiField[g]) << REGION_LSB) | REGION_MASK);
      assign hitVec[g] = (lookAddr >= entLo) && (lookAddr <= entHi);
    end
  endgenerate

  logic [ENT_W-1:0] hitIdx;

  always_comb begin
    hitIdx = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--)
      if (hitVec[i]) hitIdx = ENT_W'(i);
  end

  assign hit        = |hitVec;
  assign hitSktCode = sktCode[hitIdx];
  assign hitChnCode = chnCode[hitIdx];
  assign hitSktK    = sktK[hitIdx];
  assign hitChnM1   = chnM1[hitIdx];

  always_comb begin
    hitOffField = '0;
    for (int c = 0; c < NUM_CH; c++)
      if (lookChan == CH_W'(c)) hitOffField = offField[hitIdx][c];
  end

endmodule

// File: rtl/cadDatapath.sv
module cadDatapath import cad_pkg::*; #(
  parameter int ADDR_W = 46,
  parameter int NUM_CH = 3,
  parameter int REGION_LSB = 26,
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  cadStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CH_W-1:0]   reqChan,
  input  logic              hit,
  input  logic [1:0]        hitSktCode,
  input  logic [1:0]        hitChnCode,
  input  logic [1:0]        hitSktK,
  input  logic [1:0]        hitChnM1,
  input  logic [19:0]       hitOffField,
  output logic [ADDR_W-1:0] lookAddr,
  output logic [CH_W-1:0]   lookChan,
  output logic              stepNeedsDiv,
  output logic [ADDR_W-1:0] outAddr,
  output logic [3:0]        outSkt,
  output logic [2:0]        outChn,
  output logic              outErr
);

  logic [ADDR_W-1:0] origAddr;
  logic [CH_W-1:0]   chanR;
  logic [ADDR_W-1:0] curV;
  logic [1:0]        sktCodeR, chnCodeR, sktKR, chnM1R;
  logic              chanFirst;
  logic [ADDR_W-1:0] divQ;
  logic [1:0]        divRem;

  assign lookAddr = origAddr;
  assign lookChan = chanR;

  logic [ADDR_W-1:0] offVal;
  assign offVal = ADDR_W'(64'(hitOffField) << REGION_LSB);

  // Which interleave the current step removes
  logic isChnStep;
  logic [4:0] gSh;
  logic [1:0] kSh;
  logic [1:0] chnK;
  logic [ADDR_W-1:0] lowSrc, lowMask, shiftRes, divRes, stepRes;

  always_comb begin
    unique case (chnM1R)
      2'd1: chnK = 2'd1;
      2'd3: chnK = 2'd2;
      default: chnK = 2'd0;
    endcase
  end

  assign isChnStep    = chanFirst ? !strb.stepSel : strb.stepSel;
  assign gSh          = granBit(isChnStep ? chnCodeR : sktCodeR);
  assign kSh          = isChnStep ? chnK : sktKR;
  assign stepNeedsDiv = isChnStep && (chnM1R == 2'd2);
  assign lowSrc       = chanFirst ? curV : origAddr;
  assign lowMask      = ~({ADDR_W{1'b1}} << gSh);
  assign shiftRes     = (((curV >> gSh) >> kSh) << gSh) | (lowSrc & lowMask);
  assign divRes       = (divQ << gSh) | (lowSrc & lowMask);
  assign stepRes      = strb.useDiv ? divRes : shiftRes;

  // Restoring divide-by-three, one quotient bit per cycle
  logic [2:0] trial;
  logic       trialGe;
  assign trial   = {divRem, divQ[ADDR_W-1]};
  assign trialGe = trial >= 3'd3;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      origAddr  <= '0;
      chanR     <= '0;
      curV      <= '0;
      sktCodeR  <= '0;
      chnCodeR  <= '0;
      sktKR     <= '0;
      chnM1R    <= '0;
      chanFirst <= 1'b0;
      divQ      <= '0;
      divRem    <= '0;
      outAddr   <= '0;
      outSkt    <= '0;
      outChn    <= '0;
      outErr    <= 1'b0;
    end else begin
      if (strb.load) begin
        origAddr <= reqAddr;
        chanR    <= reqChan;
      end
      if (strb.match) begin
        curV      <= origAddr - offVal;
        sktCodeR  <= hitSktCode;
        chnCodeR  <= hitChnCode;
        sktKR     <= hitSktK;
        chnM1R    <= hitChnM1;
        chanFirst <= (hitChnM1 == 2'd2) && (granBit(hitSktCode) > granBit(hitChnCode));
      end
      if (strb.divInit) begin
        divQ   <= curV >> gSh;
        divRem <= '0;
      end else if (strb.divIter) begin
        divQ   <= {divQ[ADDR_W-2:0], trialGe};
        divRem <= trialGe ? 2'(trial - 3'd3) : trial[1:0];
      end
      if (strb.stepWr) curV <= stepRes;
      if (strb.finOk) begin
        outAddr <= stepRes;
        outSkt  <= 4'(5'd1 << sktKR);
        outChn  <= 3'(chnM1R) + 3'd1;
        outErr  <= 1'b0;
      end else if (strb.finErr) begin
        outAddr <= '0;
        outSkt  <= '0;
        outChn  <= '0;
        outErr  <= 1'b1;
      end
    end
  end

  // R6: the running remainder of a divide by three never reaches three
  a_r6_rem_bound: assert property (@(posedge clk) disable iff (!rstN)
    divRem != 2'd3);

  // R10: the captured request only changes on a load strobe
  a_r10_hold_req: assert property (@(posedge clk) disable iff (!rstN)
    !strb.load |=> $stable(origAddr));

  // R3: a published hit carries legal way counts
  a_r3_ways_legal: assert property (@(posedge clk) disable iff (!rstN)
    strb.finOk |=> ($onehot(outSkt) && outChn != 3'd0 && !outErr));

  // R2: a published miss clears the address
  a_r2_miss_zero: assert property (@(posedge clk) disable iff (!rstN)
    strb.finErr |=> (outErr && outAddr == '0));

  // hit is consumed only while matching
  logic unusedHit;
  assign unusedHit = hit;

endmodule

// File: rtl/cadControl.sv
module cadControl import cad_pkg::*; #(
  parameter int ADDR_W = 46,
  localparam int CNT_W = $clog2(ADDR_W)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       hit,
  input  logic       stepNeedsDiv,
  output cadStrobe_t strb,
  output logic       busy,
  output logic       done
);

  typedef enum logic [2:0] {S_IDLE, S_MATCH, S_STEP, S_DIV, S_FIN} cadState_t;

  cadState_t state, stateNx;
  logic stepSel, stepSelNx;
  logic [CNT_W-1:0] cnt, cntNx;
  logic doneR;

  always_comb begin
    strb      = '0;
    stateNx   = state;
    stepSelNx = stepSel;
    cntNx     = cnt;
    strb.stepSel = stepSel;
    unique case (state)
      S_IDLE: begin
        if (reqValid) begin
          strb.load = 1'b1;
          stepSelNx = 1'b0;
          stateNx   = S_MATCH;
        end
      end
      S_MATCH: begin
        strb.match = 1'b1;
        if (hit) stateNx = S_STEP;
        else begin
          strb.finErr = 1'b1;
          stateNx     = S_IDLE;
        end
      end
      S_STEP: begin
        if (stepNeedsDiv) begin
          strb.divInit = 1'b1;
          cntNx        = CNT_W'(ADDR_W - 1);
          stateNx      = S_DIV;
        end else begin
          strb.stepWr = 1'b1;
          if (stepSel) begin
            strb.finOk = 1'b1;
            stateNx    = S_IDLE;
          end else stepSelNx = 1'b1;
        end
      end
      S_DIV: begin
        strb.divIter = 1'b1;
        if (cnt == '0) stateNx = S_FIN;
        else cntNx = cnt - 1'b1;
      end
      default: begin
        strb.stepWr = 1'b1;
        strb.useDiv = 1'b1;
        if (stepSel) begin
          strb.finOk = 1'b1;
          stateNx    = S_IDLE;
        end else begin
          stepSelNx = 1'b1;
          stateNx   = S_STEP;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      stepSel <= 1'b0;
      cnt     <= '0;
      doneR   <= 1'b0;
    end else begin
      state   <= stateNx;
      stepSel <= stepSelNx;
      cnt     <= cntNx;
      doneR   <= strb.finOk | strb.finErr;
    end
  end

  assign busy = (state != S_IDLE);
  assign done = doneR;

  // R12: done lasts a single cycle
  a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R9: a divide always spends its full iteration count before finishing
  a_r9_div_exit: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_DIV && cnt != '0) |=> state == S_DIV);

endmodule

// File: rtl/chanDeinterleaver.sv
module chanDeinterleaver import cad_pkg::*; #(
  parameter int ADDR_W = 46,
  parameter int NUM_ENT = 8,
  parameter int NUM_CH = 3,
  parameter int REGION_LSB = 26,
  localparam int ENT_W = $clog2(NUM_ENT),
  localparam int CH_W = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [1:0]        cfgSel,
  input  logic [ENT_W-1:0]  cfgEntry,
  input  logic [CH_W-1:0]   cfgChan,
  input  logic [31:0]       cfgData,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [CH_W-1:0]   reqChan,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [ADDR_W-1:0] chanAddr,
  output logic [3:0]        sktWays,
  output logic [2:0]        chanWays
);

  cadStrobe_t strb;
  logic hit, stepNeedsDiv;
  logic [1:0] hitSktCode, hitChnCode, hitSktK, hitChnM1;
  logic [19:0] hitOffField;
  logic [ADDR_W-1:0] lookAddr;
  logic [CH_W-1:0] lookChan;

  cadTables #(.ADDR_W(ADDR_W), .NUM_ENT(NUM_ENT), .NUM_CH(NUM_CH), .REGION_LSB(REGION_LSB)) u_tab (
    .clk(clk), .rstN(rstN),
    .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgEntry(cfgEntry), .cfgChan(cfgChan), .cfgData(cfgData),
    .lookAddr(lookAddr), .lookChan(lookChan),
    .hit(hit), .hitSktCode(hitSktCode), .hitChnCode(hitChnCode),
    .hitSktK(hitSktK), .hitChnM1(hitChnM1), .hitOffField(hitOffField)
  );

  cadDatapath #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .REGION_LSB(REGION_LSB)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqChan(reqChan),
    .hit(hit), .hitSktCode(hitSktCode), .hitChnCode(hitChnCode),
    .hitSktK(hitSktK), .hitChnM1(hitChnM1), .hitOffField(hitOffField),
    .lookAddr(lookAddr), .lookChan(lookChan), .stepNeedsDiv(stepNeedsDiv),
    .outAddr(chanAddr), .outSkt(sktWays), .outChn(chanWays), .outErr(error)
  );

  cadControl #(.ADDR_W(ADDR_W)) u_ctl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .hit(hit),
    .stepNeedsDiv(stepNeedsDiv), .strb(strb), .busy(busy), .done(done)
  );

  // R2: a miss result never carries an address or way counts
  a_r2_miss_outputs: assert property (@(posedge clk) disable iff (!rstN)
    (done && error) |-> (chanAddr == '0 && sktWays == 4'd0 && chanWays == 3'd0));

  // R12: outputs hold between results
  a_r12_hold_outputs: assert property (@(posedge clk) disable iff (!rstN)
    !done |=> (done || ($stable(chanAddr) && $stable(error))));

endmodule

// File: tb/sim_chanDeinterleaver.sv
module sim_chanDeinterleaver;

  localparam int AW = 46;
  localparam longint unsigned AMASK = (64'd1 << AW) - 64'd1;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN, cfgWe, reqValid;
  logic [1:0] cfgSel;
  logic [2:0] cfgEntry;
  logic [1:0] cfgChan, reqChan;
  logic [31:0] cfgData;
  logic [AW-1:0] reqAddr;
  logic busy, done, error;
  logic [AW-1:0] chanAddr;
  logic [3:0] sktWays;
  logic [2:0] chanWays;

  chanDeinterleaver u0 (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgEntry(cfgEntry),
    .cfgChan(cfgChan), .cfgData(cfgData), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqChan(reqChan), .busy(busy), .done(done), .error(error), .chanAddr(chanAddr),
    .sktWays(sktWays), .chanWays(chanWays)
  );

  int nRun = 0;
  int nFail = 0;
  bit finished = 1'b0;

  bit [31:0] mBase [8];
  bit [31:0] mWay [8];
  bit [31:0] mOff [8][3];

  task automatic check(input bit ok, input string tag, input longint unsigned act,
                       input longint unsigned exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int gpos(input bit [1:0] c);
    case (c)
      2'd0: return 6;
      2'd1: return 8;
      2'd2: return 12;
      default: return 30;
    endcase
  endfunction

  function automatic longint unsigned ilv(input longint unsigned x, input int s,
                                          input int w, input longint unsigned low);
    longint unsigned m;
    m = (64'd1 << s) - 64'd1;
    return ((((x >> s) / longint'(w)) << s) | (low & m)) & AMASK;
  endfunction

  // Reference model built from the requirements
  task automatic model(input longint unsigned a, input int ch, output bit hit,
                       output longint unsigned res, output int skt, output int chn,
                       output int lat, output bit chFirst);
    int idx;
    longint unsigned lo, hi, off, v;
    int gs, gc;
    idx = -1;
    for (int i = 0; i < 8; i++) begin
      lo = longint'(mBase[i][31:12]) << 26;
      hi = (longint'(mWay[i][31:12]) << 26) | 64'h3FFFFFF;
      if (idx < 0 && a >= lo && a <= hi) idx = i;
    end
    hit = (idx >= 0);
    chFirst = 1'b0;
    if (!hit) begin
      res = 0; skt = 0; chn = 0; lat = 1;
      return;
    end
    gs  = gpos(mBase[idx][5:4]);
    gc  = gpos(mBase[idx][7:6]);
    skt = 1 << mWay[idx][11:10];
    chn = int'(mWay[idx][9:8]) + 1;
    off = longint'(mOff[idx][ch][23:4]) << 26;
    v = (a - off) & AMASK;
    if (chn == 3 && gs > gc) begin
      chFirst = 1'b1;
      v = ilv(v, gc, chn, v);
      v = ilv(v, gs, skt, v);
    end else begin
      v = ilv(v, gs, skt, a);
      v = ilv(v, gc, chn, a);
    end
    res = v;
    lat = (chn == 3) ? 50 : 3;
  endtask

  task automatic cfgWrite(input bit [1:0] sel, input int ent, input int ch, input bit [31:0] d);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgEntry = 3'(ent); cfgChan = 2'(ch); cfgData = d;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      2'd0: mBase[ent] = d;
      2'd1: mWay[ent] = d;
      2'd2: if (ch < 3) mOff[ent][ch] = d;
      default: ;
    endcase
  endtask

  task automatic runReq(input longint unsigned a, input int ch, input bit inject, input string tag);
    bit hit, chFirst, got;
    longint unsigned expA;
    int expS, expC, lat, n;
    string atag;
    model(a, ch, hit, expA, expS, expC, lat, chFirst);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = AW'(a); reqChan = 2'(ch);
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    n = 0; got = 1'b0;
    while (!got && n < 200) begin
      @(posedge clk);
      n++;
      @(negedge clk);
      if (done) got = 1'b1;
      else if (inject && n == 4) begin
        check(busy, "R10 busy while in flight", longint'(busy), 1);
        reqValid = 1'b1; reqAddr = AW'(a ^ 64'h0000_0001_2345_6780); reqChan = 2'(ch ^ 1);
      end else reqValid = 1'b0;
    end
    reqValid = 1'b0;
    check(got, "R9 done seen", longint'(got), 1);
    check(n == lat, {tag, " R9 latency"}, longint'(n), longint'(lat));
    check(error == !hit, {tag, " R2 error flag"}, longint'(error), longint'(!hit));
    atag = !hit ? "R2" : (chFirst ? "R7" : "R8");
    if (inject) atag = {atag, " R10"};
    check(longint'(chanAddr) == expA, {tag, " ", atag, " chanAddr"}, longint'(chanAddr), expA);
    check(int'(sktWays) == expS, {tag, " R3 sktWays"}, longint'(sktWays), longint'(expS));
    check(int'(chanWays) == expC, {tag, " R3 chanWays"}, longint'(chanWays), longint'(expC));
    @(negedge clk);
    check(!done && longint'(chanAddr) == expA, {tag, " R12 pulse and hold"},
          longint'(chanAddr), expA);
  endtask

  function automatic bit [31:0] mkBase(input int lo, input int sg, input int cg);
    return {20'(lo), 4'd0, 2'(cg), 2'(sg), 4'd0};
  endfunction
  function automatic bit [31:0] mkWay(input int hi, input int sk, input int cm1);
    return {20'(hi), 2'(sk), 2'(cm1), 8'd0};
  endfunction

  function automatic longint unsigned inEntry(input int lo, input int hi);
    longint unsigned span, r;
    span = (longint'(hi - lo + 1)) << 26;
    r = {32'($urandom), 32'($urandom)};
    return (longint'(lo) << 26) + (r % span);
  endfunction

  // Entry setup: {socket code, channel code, socket k, channel ways-1}
  int sgT [8] = '{0, 2, 0, 3, 1, 3, 1, 0};
  int cgT [8] = '{1, 0, 1, 3, 2, 2, 1, 2};
  int skT [8] = '{0, 1, 2, 3, 1, 0, 2, 1};
  int cwT [8] = '{0, 2, 2, 3, 1, 2, 2, 0};

  initial begin
    void'($urandom(32'd20240611));
    rstN = 1'b0; cfgWe = 1'b0; cfgSel = '0; cfgEntry = '0; cfgChan = '0; cfgData = '0;
    reqValid = 1'b0; reqAddr = '0; reqChan = '0;
    for (int i = 0; i < 8; i++) begin
      mBase[i] = 0; mWay[i] = 0;
      for (int c = 0; c < 3; c++) mOff[i][c] = 0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!busy && !done && !error, "R12 reset flags", longint'({busy, done, error}), 0);
    check(chanAddr == '0 && sktWays == '0 && chanWays == '0, "R12 reset data",
          longint'(chanAddr), 0);
    rstN = 1'b1;

    // R11: load the whole table through the write port
    for (int i = 0; i < 8; i++) begin
      int lo;
      lo = (i == 7) ? 6 * 64 : i * 64;
      cfgWrite(2'd0, i, 0, mkBase(lo, sgT[i], cgT[i]));
      cfgWrite(2'd1, i, 0, mkWay(i * 64 + 63, skT[i], cwT[i]));
      for (int c = 0; c < 3; c++)
        cfgWrite(2'd2, i, c, {8'd0, 20'($urandom % (lo + 1)), 4'd0});
    end
    cfgWrite(2'd3, 0, 0, 32'hFFFF_FFFF); // select 3 writes nothing

    // R4 R5: every entry, every channel
    for (int i = 0; i < 7; i++)
      for (int c = 0; c < 3; c++)
        runReq(inEntry(i * 64, i * 64 + 63), c, 1'b0, "R4 R5 directed");

    // R1: inclusive bounds and lowest index wins on overlap
    runReq(longint'(128) << 26, 1, 1'b0, "R1 base edge");
    runReq((longint'(191) << 26) | 64'h3FFFFFF, 2, 1'b0, "R1 limit edge");
    runReq(inEntry(6 * 64, 6 * 64 + 63), 0, 1'b0, "R1 overlap first wins");
    runReq(inEntry(7 * 64, 7 * 64 + 63), 0, 1'b0, "R1 upper entry");

    // R2: misses
    runReq(longint'(512) << 26, 0, 1'b0, "R2 just above");
    runReq(64'h0000_0100_0000_0000, 2, 1'b0, "R2 far");

    // R10: request during a three-way lookup is dropped
    runReq(inEntry(64, 127), 0, 1'b1, "R10 ignore");
    runReq(inEntry(128, 191), 2, 1'b1, "R10 ignore socket-first");

    // R11: rewrite entry 0 and check the new ways are used
    cfgWrite(2'd1, 0, 0, mkWay(63, 2, 1));
    runReq(inEntry(0, 63), 1, 1'b0, "R11 rewrite");
    cfgWrite(2'd2, 0, 1, {8'd0, 20'd5, 4'd0});
    runReq(inEntry(0, 63), 1, 1'b0, "R11 R5 new offset");

    // Random traffic
    for (int t = 0; t < 150; t++) begin
      longint unsigned a;
      a = {32'($urandom), 32'($urandom)};
      a = a & 64'h0000_0007_FFFF_FFFF;
      if ($urandom % 10 == 0) a = a | (64'd1 << 40);
      runReq(a, int'($urandom % 3), 1'b0, "random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nRun++;
      nFail++;
      $display("FAIL watchdog R9 actual=%0h expected=%0h", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

endmodule